// File: doc/BRIEF.md
# Command and Response Byte Channel with Status Register

This block is the byte transfer path between a host and a security-device engine. The host reaches it through a locality window. The window holds two registers: a 32-bit status register and a data register. Through the data register the host writes a command one byte at a time. The host then starts execution and reads the response back one byte at a time. The status register reports the following to the host:
- which phase the transfer is in;
- how many bytes may move next (the burst count);
- whether more command bytes are expected;
- whether response bytes are waiting.

Only the locality named on the active-locality input is served. Arbitration between localities happens outside this block.

On the engine side the block plays the finished command out as a valid/ready byte stream and marks the final byte. It then takes in a response byte stream until the end marker arrives. A single buffer of `DEPTH` bytes holds the command first and the response afterwards. The total command length is read from the command header: bytes 2 to 5, big-endian. The expect flag drops on exactly the byte that completes that length.

Top module: `ccr_top`

## Requirements
- R1: Status word layout: bit 7 valid, bit 6 command ready, bit 5 go, bit 4 data available, bit 3 expect, bit 1 response retry, bits 23:8 burst count, bits 27:26 family, which always reads 01. After reset, the status at offset 0x018 of the active locality reads a low byte of 0x00 and a burst count of DEPTH, which is at least 128.
- R2: In the idle, receiving or completed phase, writing the status word with bit 6 set enters the ready phase, where the low byte reads 0x40 and the burst count reads DEPTH. Any unread response is dropped, so a later data read returns all ones.
- R3: Each accepted command byte (bits 7:0 of a write to offset 0x024) lowers the burst count by one, so it reads DEPTH minus the bytes received. The low byte reads 0x88 while more bytes are expected and 0x80 once the command is complete.
- R4: The command length is the big-endian 32-bit value in command bytes 2 to 5. Expect clears when the received count reaches the larger of 6 and that length. Data writes after that point are ignored and leave the burst count unchanged.
- R5: A status write with bit 5 set while expect is still set is ignored. Once the command is complete, the same write enters the executing phase, where the low byte reads 0x80 and the burst count reads 0.
- R6: During execution the command bytes are sent in order on the command stream, with the last flag on the final byte only. Valid, data and last stay stable while ready is low.
- R7: After the command is sent, the response stream is accepted (ready high, command valid low) up to and including the byte marked last. The low byte then reads 0x90 and the burst count reads the response length, capped at DEPTH; bytes beyond DEPTH are dropped.
- R8: In the completed phase, each data read returns the next response byte in bits 7:0 (upper bits zero) and lowers the burst count by one. Once every byte has been read, a data read returns 0xFFFFFFFF, and the status low byte reads 0x80 with a burst count of 0.
- R9: In the completed phase, a status write with bit 1 set rewinds the response read position, so the burst count returns to the full response length and the bytes are read again from the first.
- R10: Any access whose address locality field (bits 14:12) does not match the active locality, or any access while no locality is active, reads 0xFFFFFFFF and changes no state.
- R11: A command whose header length exceeds DEPTH fills the buffer; further bytes are dropped, the burst count stays at 0, expect stays set and go is ignored until bit 6 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| act_valid | input | 1 | A locality currently owns the channel |
| act_loc | input | LOC_W | Number of the owning locality |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 12+LOC_W | Locality in the upper bits, register offset in bits 11:0 |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| cmd_valid | output | 1 | Command byte available to the engine |
| cmd_ready | input | 1 | Engine takes the command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final command byte |
| rsp_valid | input | 1 | Response byte from the engine |
| rsp_ready | output | 1 | Block accepts response bytes |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |

## Verification
The bench aims at the byte that completes the header length. A design that clears expect one byte early or one byte late shows a wrong low byte on that exact status read. It also stalls the command stream mid-command and sends a response longer than the buffer. A design that advances on a stalled byte, or lets the count wrap, shows a wrong byte order or a wrong capped burst count. Other corner cases covered:
- A go request before the command is complete must leave the phase unchanged, or the engine would see a truncated command.
- A rewind and a command-ready request after partial reads must leave the bytes in a known place, or stale response bytes would be read.
- Accesses from a foreign locality must not move any counter, or the burst count seen by the owner would shift.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READY   = 3'd1,
        ST_RECV    = 3'd2,
        ST_SEND    = 3'd3,
        ST_COLLECT = 3'd4,
        ST_DONE    = 3'd5
    } ccr_state_e;

    localparam logic [11:0] OFF_STATUS = 12'h018;
    localparam logic [11:0] OFF_FIFO   = 12'h024;

    localparam int BIT_VALID = 7;
    localparam int BIT_CRDY  = 6;
    localparam int BIT_GO    = 5;
    localparam int BIT_DAV   = 4;
    localparam int BIT_EXP   = 3;
    localparam int BIT_RETRY = 1;

    localparam logic [1:0] FAMILY_CODE = 2'b01;
    localparam int         HDR_BYTES   = 6;

endpackage

// File: rtl/ccr_hostdec.sv
module ccr_hostdec
    import ccr_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    localparam int AW     = 12 + LOC_W
) (
    input  logic             host_valid_i,
    input  logic             host_write_i,
    input  logic [AW-1:0]    host_addr_i,
    input  logic             act_valid_i,
    input  logic [LOC_W-1:0] act_loc_i,
    output logic             sts_sel_o,
    output logic             fifo_sel_o,
    output logic             sts_wr_o,
    output logic             fifo_wr_o,
    output logic             fifo_rd_o
);
    logic [LOC_W-1:0] loc;
    logic [11:0]      off;
    logic             owner;

    always_comb begin
        loc        = host_addr_i[AW-1:12];
        off        = host_addr_i[11:0];
        owner      = act_valid_i && (loc == act_loc_i) && (32'(loc) < NUM_LOC);
        sts_sel_o  = host_valid_i && owner && (off == OFF_STATUS);
        fifo_sel_o = host_valid_i && owner && (off == OFF_FIFO);
        sts_wr_o   = sts_sel_o && host_write_i;
        fifo_wr_o  = fifo_sel_o && host_write_i;
        fifo_rd_o  = fifo_sel_o && !host_write_i;
    end

endmodule

// File: rtl/ccr_buf.sv
module ccr_buf #(
    parameter int DEPTH   = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [CW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [CW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem [DEPTH];
    logic       unused_top;

    assign unused_top = waddr_i[CW-1] ^ raddr_i[CW-1];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i[AW-1:0]] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i[AW-1:0]];

endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
    import ccr_pkg::*;
#(
    parameter int DEPTH   = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sts_wr_i,
    input  logic          fifo_wr_i,
    input  logic          fifo_rd_i,
    input  logic [7:0]    wbyte_i,
    input  logic [7:0]    buf_rdata_i,
    output logic          buf_we_o,
    output logic [CW-1:0] buf_waddr_o,
    output logic [7:0]    buf_wdata_o,
    output logic [CW-1:0] buf_raddr_o,
    output logic [31:0]   status_o,
    output logic [31:0]   fifo_rdata_o,
    output logic          cmd_valid_o,
    input  logic          cmd_ready_i,
    output logic          cmd_last_o,
    input  logic          rsp_valid_i,
    input  logic [7:0]    rsp_data_i,
    input  logic          rsp_last_i,
    output logic          rsp_ready_o
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        ccr_state_e    st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] sidx;
        logic [CW-1:0] rlen;
        logic [CW-1:0] rptr;
        logic [31:0]   len;
    } ctrl_t;

    ctrl_t q, d;
    logic  expect_w;
    logic  full_w;
    logic  take_w;
    logic  unread_w;
    logic [7:0]  lo_w;
    logic [15:0] burst_w;

    always_comb begin
        d           = q;
        buf_we_o    = 1'b0;
        buf_waddr_o = q.cnt;
        buf_wdata_o = wbyte_i;
        buf_raddr_o = (q.st == ST_SEND) ? q.sidx : q.rptr;
        cmd_valid_o = 1'b0;
        cmd_last_o  = 1'b0;
        rsp_ready_o = 1'b0;
        expect_w    = (q.cnt < CW'(HDR_BYTES)) || (32'(q.cnt) < q.len);
        full_w      = (q.cnt == FULL);
        unread_w    = (q.rptr != q.rlen);
        take_w      = fifo_wr_i &&
                      ((q.st == ST_READY) || ((q.st == ST_RECV) && expect_w && !full_w));

        case (q.st)
            ST_SEND: begin
                cmd_valid_o = 1'b1;
                cmd_last_o  = (q.sidx == q.cnt - ONE);
                if (cmd_ready_i) begin
                    if (cmd_last_o) begin
                        d.st   = ST_COLLECT;
                        d.rlen = '0;
                    end else begin
                        d.sidx = q.sidx + ONE;
                    end
                end
            end
            ST_COLLECT: begin
                rsp_ready_o = 1'b1;
                if (rsp_valid_i) begin
                    if (q.rlen != FULL) begin
                        buf_we_o    = 1'b1;
                        buf_waddr_o = q.rlen;
                        buf_wdata_o = rsp_data_i;
                        d.rlen      = q.rlen + ONE;
                    end
                    if (rsp_last_i) begin
                        d.st   = ST_DONE;
                        d.rptr = '0;
                    end
                end
            end
            default: begin
                if (sts_wr_i && wbyte_i[BIT_CRDY]) begin
                    d.st   = ST_READY;
                    d.cnt  = '0;
                    d.sidx = '0;
                    d.rlen = '0;
                    d.rptr = '0;
                    d.len  = '0;
                end else begin
                    if (take_w) begin
                        buf_we_o = 1'b1;
                        d.cnt    = q.cnt + ONE;
                        d.st     = ST_RECV;
                        if ((q.cnt >= CW'(2)) && (q.cnt <= CW'(5))) begin
                            d.len = {q.len[23:0], wbyte_i};
                        end
                    end
                    if ((q.st == ST_RECV) && sts_wr_i && wbyte_i[BIT_GO] && !expect_w) begin
                        d.st   = ST_SEND;
                        d.sidx = '0;
                    end
                    if ((q.st == ST_DONE) && fifo_rd_i && unread_w) begin
                        d.rptr = q.rptr + ONE;
                    end
                    if ((q.st == ST_DONE) && sts_wr_i && wbyte_i[BIT_RETRY]) begin
                        d.rptr = '0;
                    end
                end
            end
        endcase
    end

    always_comb begin
        lo_w    = 8'h00;
        burst_w = 16'h0000;
        case (q.st)
            ST_IDLE: begin
                burst_w = 16'(FULL);
            end
            ST_READY: begin
                lo_w[BIT_CRDY] = 1'b1;
                burst_w        = 16'(FULL);
            end
            ST_RECV: begin
                lo_w[BIT_VALID] = 1'b1;
                lo_w[BIT_EXP]   = expect_w;
                burst_w         = 16'(FULL - q.cnt);
            end
            ST_DONE: begin
                lo_w[BIT_VALID] = 1'b1;
                lo_w[BIT_DAV]   = unread_w;
                burst_w         = 16'(q.rlen - q.rptr);
            end
            default: begin
                lo_w[BIT_VALID] = 1'b1;
            end
        endcase
        status_o     = {4'h0, FAMILY_CODE, 2'b00, burst_w, lo_w};
        fifo_rdata_o = ((q.st == ST_DONE) && unread_w) ? {24'h0, buf_rdata_i} : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sidx: '0, rlen: '0, rptr: '0, len: '0};
        end else begin
            q <= d;
        end
    end

    // R3: every accepted command byte lowers the reported burst count by one
    assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_w && !(sts_wr_i && wbyte_i[BIT_CRDY])
        |=> status_o[23:8] == $past(status_o[23:8]) - 16'd1);

    // R5: go while bytes are still expected leaves the block receiving
    assert_go_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RECV) && sts_wr_i && wbyte_i[BIT_GO] && !wbyte_i[BIT_CRDY] && expect_w
        |=> q.st == ST_RECV);

    // R6: a stalled command byte is held
    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i
        |=> cmd_valid_o && $stable(buf_rdata_i) && $stable(cmd_last_o));

    // R7: the two engine-side directions never overlap
    assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, rsp_ready_o}));

    // R8: a data read with bytes pending advances by exactly one
    assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE) && fifo_rd_i && unread_w
        |=> status_o[23:8] == $past(status_o[23:8]) - 16'd1);

    // R10: without an owner access the host-driven phases do not move
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr_i && !fifo_wr_i && !fifo_rd_i &&
        (q.st inside {ST_IDLE, ST_READY, ST_RECV, ST_DONE})
        |=> $stable(status_o));

endmodule

// File: rtl/ccr_top.sv
module ccr_top #(
    parameter int DEPTH   = 256,
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    localparam int AW     = 12 + LOC_W,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [LOC_W-1:0] act_loc,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [AW-1:0]    host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [7:0]       cmd_data,
    output logic             cmd_last,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_last
);
    logic          sts_sel, fifo_sel, sts_wr, fifo_wr, fifo_rd;
    logic          buf_we;
    logic [CW-1:0] buf_waddr, buf_raddr;
    logic [7:0]    buf_wdata, buf_rdata;
    logic [31:0]   status, fifo_rdata;
    logic          unused_hi;

    assign unused_hi = ^host_wdata[31:8];

    ccr_hostdec #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
        .host_valid_i (host_valid),
        .host_write_i (host_write),
        .host_addr_i  (host_addr),
        .act_valid_i  (act_valid),
        .act_loc_i    (act_loc),
        .sts_sel_o    (sts_sel),
        .fifo_sel_o   (fifo_sel),
        .sts_wr_o     (sts_wr),
        .fifo_wr_o    (fifo_wr),
        .fifo_rd_o    (fifo_rd)
    );

    ccr_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (buf_wdata),
        .raddr_i (buf_raddr),
        .rdata_o (buf_rdata)
    );

    ccr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sts_wr_i     (sts_wr),
        .fifo_wr_i    (fifo_wr),
        .fifo_rd_i    (fifo_rd),
        .wbyte_i      (host_wdata[7:0]),
        .buf_rdata_i  (buf_rdata),
        .buf_we_o     (buf_we),
        .buf_waddr_o  (buf_waddr),
        .buf_wdata_o  (buf_wdata),
        .buf_raddr_o  (buf_raddr),
        .status_o     (status),
        .fifo_rdata_o (fifo_rdata),
        .cmd_valid_o  (cmd_valid),
        .cmd_ready_i  (cmd_ready),
        .cmd_last_o   (cmd_last),
        .rsp_valid_i  (rsp_valid),
        .rsp_data_i   (rsp_data),
        .rsp_last_i   (rsp_last),
        .rsp_ready_o  (rsp_ready)
    );

    assign cmd_data   = buf_rdata;
    assign host_rdata = sts_sel ? status : (fifo_sel ? fifo_rdata : '1);

endmodule

// File: tb/sim_ccr_top.sv
`timescale 1ns/1ps
module sim_ccr_top;
    localparam int DEPTH = 256;
    localparam logic [11:0] OS = 12'h018;
    localparam logic [11:0] OF = 12'h024;
    localparam logic [31:0] FAM = 32'h0400_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        act_valid = 1;
    logic [2:0]  act_loc = 0;
    logic        host_valid = 0, host_write = 0;
    logic [14:0] host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        cmd_valid, cmd_last, rsp_ready;
    logic        cmd_ready = 0;
    logic [7:0]  cmd_data;
    logic        rsp_valid = 0, rsp_last = 0;
    logic [7:0]  rsp_data = 0;

    always #5 clk = ~clk;

    ccr_top u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    int          m_st = 0;      // 0 idle 1 ready 2 recv 3 exec 4 done
    byte unsigned m_cmd[$];
    byte unsigned m_rsp[$];
    int          m_rd = 0;
    int          m_act = 0;
    bit          m_actv = 1;

    function automatic bit m_expect();
        int unsigned l;
        if (m_cmd.size() < 6) return 1'b1;
        l = {m_cmd[2], m_cmd[3], m_cmd[4], m_cmd[5]};
        return 32'(m_cmd.size()) < l;
    endfunction

    function automatic logic [31:0] m_status();
        int un;
        case (m_st)
            0: return FAM | (32'(DEPTH) << 8);
            1: return FAM | (32'(DEPTH) << 8) | 32'h40;
            2: return FAM | (32'(DEPTH - m_cmd.size()) << 8) | 32'h80 | (m_expect() ? 32'h08 : 32'h0);
            3: return FAM | 32'h80;
            default: begin
                un = m_rsp.size() - m_rd;
                return FAM | (32'(un) << 8) | 32'h80 | (un > 0 ? 32'h10 : 32'h0);
            end
        endcase
    endfunction

    function automatic bit owner(int loc);
        return m_actv && loc == m_act;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(bit w, int loc, logic [11:0] off, logic [31:0] dat, output logic [31:0] r);
        @(negedge clk);
        host_valid = 1;
        host_write = w;
        host_addr  = {loc[2:0], off};
        host_wdata = dat;
        #1 r = host_rdata;
        @(posedge clk);
        #1 host_valid = 0;
    endtask

    task automatic rd_sts(string tag, int loc);
        logic [31:0] r;
        bus(0, loc, OS, 0, r);
        chk(tag, r, owner(loc) ? m_status() : 32'hFFFF_FFFF);
    endtask

    task automatic wr_sts(int loc, logic [31:0] dat);
        logic [31:0] r;
        bus(1, loc, OS, dat, r);
        if (!owner(loc) || m_st == 3) return;
        if (dat[6]) begin
            m_st = 1; m_cmd.delete(); m_rsp.delete(); m_rd = 0;
        end else if (dat[5] && m_st == 2 && !m_expect()) begin
            m_st = 3;
        end else if (dat[1] && m_st == 4) begin
            m_rd = 0;
        end
    endtask

    task automatic wr_fifo(int loc, byte unsigned b);
        logic [31:0] r;
        bus(1, loc, OF, {24'h0, b}, r);
        if (owner(loc) && (m_st == 1 || (m_st == 2 && m_expect() && m_cmd.size() < DEPTH))) begin
            m_cmd.push_back(b);
            m_st = 2;
        end
    endtask

    task automatic rd_fifo(string tag, int loc);
        logic [31:0] r;
        bit has;
        bus(0, loc, OF, 0, r);
        has = owner(loc) && m_st == 4 && m_rd < m_rsp.size();
        chk(tag, r, has ? {24'h0, m_rsp[m_rd]} : 32'hFFFF_FFFF);
        if (has) m_rd++;
    endtask

    task automatic send_cmd(int loc, byte unsigned bytes[$]);
        foreach (bytes[i]) begin
            wr_fifo(loc, bytes[i]);
            rd_sts("R3 burst/expect after command byte", loc);
        end
    endtask

    task automatic backend(int rsp_n, int seed);
        int idx = 0;
        bit held = 0;
        int n = m_cmd.size();
        while (idx < n) begin
            @(negedge clk);
            cmd_ready = !((idx % 4 == 1) && !held);
            held = !cmd_ready;
            #1 chk("R6 command stream byte", {23'h0, cmd_valid, cmd_last, cmd_data},
                   {23'h0, 1'b1, idx == n - 1, m_cmd[idx]});
            @(posedge clk);
            if (cmd_ready) idx++;
        end
        for (int k = 0; k < rsp_n; k++) begin
            @(negedge clk);
            cmd_ready = 0;
            rsp_valid = 1;
            rsp_data  = 8'(k * 7 + seed);
            rsp_last  = (k == rsp_n - 1);
            #1 chk("R7 response accepted", {30'h0, rsp_ready, cmd_valid}, 32'h2);
            @(posedge clk);
        end
        @(negedge clk);
        rsp_valid = 0;
        rsp_last  = 0;
        m_rsp.delete();
        for (int k = 0; k < rsp_n && k < DEPTH; k++) m_rsp.push_back(8'(k * 7 + seed));
        m_rd = 0;
        m_st = 4;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        byte unsigned c1[$];
        byte unsigned c2[$];
        byte unsigned c3[$];
        c1 = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0a, 8'h00, 8'h00, 8'h01, 8'h7b};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset view
        rd_sts("R1 status after reset", 0);
        chk("R1 burst at least 128", 32'(u0.host_rdata[23:8] >= 16'd128), 32'd1);

        // R10 foreign locality
        rd_sts("R10 foreign status read", 2);
        wr_sts(2, 32'h40);
        rd_sts("R10 owner unchanged after foreign write", 0);

        // R2 ready
        wr_sts(0, 32'h40);
        rd_sts("R2 ready phase", 0);

        // R3 / R4 full command, then surplus byte
        send_cmd(0, c1);
        wr_fifo(0, 8'hee);
        rd_sts("R4 surplus byte ignored", 0);
        wr_fifo(1, 8'hdd);
        rd_sts("R10 foreign data write ignored", 0);

        // R5 go
        wr_sts(0, 32'h20);
        rd_sts("R5 executing phase", 0);
        backend(14, 3);
        rd_sts("R7 completed phase", 0);

        // R8 partial reads, R9 rewind, full read, empty read
        for (int i = 0; i < 5; i++) begin
            rd_fifo("R8 response byte", 0);
            rd_sts("R8 burst after read", 0);
        end
        wr_sts(0, 32'h02);
        rd_sts("R9 rewind restores burst", 0);
        for (int i = 0; i < 14; i++) rd_fifo("R9 reread byte", 0);
        rd_fifo("R8 empty read", 0);
        rd_sts("R8 drained status", 0);
        rd_fifo("R10 foreign data read", 4);

        // R2 discard unread response
        wr_sts(0, 32'h40);
        send_cmd(0, c1);
        wr_sts(0, 32'h20);
        backend(9, 11);
        rd_fifo("R8 read before discard", 0);
        wr_sts(0, 32'h40);
        rd_sts("R2 ready after discard", 0);
        rd_fifo("R2 discarded data read", 0);

        // R5 early go
        c2 = '{8'h80, 8'h01, 8'h00};
        send_cmd(0, c2);
        wr_sts(0, 32'h20);
        rd_sts("R5 early go ignored", 0);
        wr_sts(0, 32'h40);
        rd_sts("R2 abort from receiving", 0);

        // R11 oversize command
        c3 = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h02, 8'h00};
        for (int i = 0; i < 254; i++) c3.push_back(8'(i));
        send_cmd(0, c3);
        rd_sts("R11 buffer full, expect set", 0);
        wr_sts(0, 32'h20);
        rd_sts("R11 go ignored when full", 0);
        wr_sts(0, 32'h40);

        // other locality, short command, oversize response
        @(negedge clk);
        act_loc = 3;
        m_act   = 3;
        rd_sts("R10 old owner now foreign", 0);
        wr_sts(3, 32'h40);
        send_cmd(3, '{8'h80, 8'h02, 8'h00, 8'h00, 8'h00, 8'h06});
        wr_sts(3, 32'h20);
        backend(300, 1);
        rd_sts("R7 response capped at DEPTH", 3);
        rd_fifo("R7 first byte after cap", 3);

        @(negedge clk);
        act_valid = 0;
        m_actv    = 0;
        rd_sts("R10 no owner", 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule